// File: doc/BRIEF.md
# ALU with Condition-Code Unit

This block is the execute-stage arithmetic core of a small 32-bit processor. It joins a combinational arithmetic/logic unit to a three-flag condition-code register and a branch evaluator. The datapath takes two operands. A source operand A and a destination operand B are combined under a 4-bit operation code. The operation code selects add, subtract (B minus A), bitwise AND or bitwise XOR.

When the set-flags input is high on a clock edge, the overflow, zero and sign flags of that operation are stored. Only operate-class instructions drive that input. A separate 4-bit jump code selects one of seven branch conditions. The branch output is evaluated from the stored flags, so a conditional jump tests the flags left by the most recent flag-setting operation.

Codes outside the defined ranges produce a zero result or a not-taken branch. They also raise an error output of their own.

Top module: `alu_cc_unit`

## Requirements
- R1: With operation code 0 the result is A + B, modulo 2^32.
- R2: With operation code 1 the result is B - A, modulo 2^32.
- R3: Operation code 2 gives A AND B and operation code 3 gives A XOR B, bit by bit.
- R4: On a rising clock edge with set_cc high and a valid operation code, zf_q becomes 1 exactly when the result is zero, and sf_q becomes bit 31 of the result.
- R5: On the same kind of edge, of_q is loaded with the signed overflow of the operation. For add and subtract this is 1 when the true signed value lies outside the signed 32-bit range. For AND and XOR it is 0.
- R6: The stored flags keep their value across any edge where set_cc is low.
- R7: While rst_n is low, and after it is released, the flags read zf_q=1, sf_q=0, of_q=0.
- R8: The branch output follows the stored flags, with lt = sf_q XOR of_q:
  - code 0 is always taken;
  - code 1 is taken on lt OR zf_q;
  - code 2 is taken on lt;
  - code 3 is taken on zf_q;
  - code 4 is taken on NOT zf_q;
  - code 5 is taken on NOT lt;
  - code 6 is taken on NOT lt AND NOT zf_q.
- R9: An operation code above 3 gives result 0 and raises alu_fn_bad. With such a code the flags are not updated, even when set_cc is high.
- R10: A jump code above 6 gives take_branch 0 and raises jmp_fn_bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | Source operand A |
| opnd_b | input | 32 | Destination operand B |
| alu_fn | input | 4 | Operation code |
| set_cc | input | 1 | Load the condition codes at the next edge |
| jmp_fn | input | 4 | Jump condition code |
| result | output | 32 | Operation result |
| of_q | output | 1 | Stored signed-overflow flag |
| zf_q | output | 1 | Stored zero flag |
| sf_q | output | 1 | Stored sign flag |
| take_branch | output | 1 | Selected jump condition is met |
| alu_fn_bad | output | 1 | Operation code is undefined |
| jmp_fn_bad | output | 1 | Jump code is undefined |

## Verification
The flag store is the only state in the block. A wrong flag appears at of_q, zf_q or sf_q one edge after the flag-setting operation. It also shows on take_branch in the same cycle, as soon as a jump code that depends on that flag is selected. The bench therefore compares the three flags after every edge against its own model. It sweeps the jump codes against the stored flags, so a missed load or a wrong hold shows up within one cycle. Signed boundary operands are used to expose overflow errors, which random operands rarely reach.

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   alu_fn,
  input  logic         set_cc,
  input  logic [3:0]   jmp_fn,
  output logic [W-1:0] result,
  output logic         of_q,
  output logic         zf_q,
  output logic         sf_q,
  output logic         take_branch,
  output logic         alu_fn_bad,
  output logic         jmp_fn_bad
);

  localparam int MSB = W - 1;

  logic [W-1:0] sum, diff;
  logic         of_next;
  logic         lt;

  assign sum  = opnd_a + opnd_b;
  assign diff = opnd_b - opnd_a;

  assign alu_fn_bad = alu_fn > 4'd3;
  assign jmp_fn_bad = jmp_fn > 4'd6;

  always_comb begin
    result  = '0;
    of_next = 1'b0;
    case (alu_fn)
      4'd0: begin
        result  = sum;
        of_next = (opnd_a[MSB] == opnd_b[MSB]) && (sum[MSB] != opnd_a[MSB]);
      end
      4'd1: begin
        result  = diff;
        of_next = (opnd_a[MSB] != opnd_b[MSB]) && (diff[MSB] != opnd_b[MSB]);
      end
      4'd2: result = opnd_a & opnd_b;
      4'd3: result = opnd_a ^ opnd_b;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      of_q <= 1'b0;
      zf_q <= 1'b1;
      sf_q <= 1'b0;
    end else if (set_cc && !alu_fn_bad) begin
      of_q <= of_next;
      zf_q <= (result == '0);
      sf_q <= result[MSB];
    end
  end

  assign lt = sf_q ^ of_q;

  always_comb begin
    case (jmp_fn)
      4'd0: take_branch = 1'b1;
      4'd1: take_branch = lt | zf_q;
      4'd2: take_branch = lt;
      4'd3: take_branch = zf_q;
      4'd4: take_branch = ~zf_q;
      4'd5: take_branch = ~lt;
      4'd6: take_branch = ~lt & ~zf_q;
      default: take_branch = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   alu_fn,
  input logic         set_cc,
  input logic [3:0]   jmp_fn,
  input logic [W-1:0] result,
  input logic         of_q,
  input logic         zf_q,
  input logic         sf_q,
  input logic         take_branch
);

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !set_cc |=> ($stable(of_q) && $stable(zf_q) && $stable(sf_q))); // R6

  AST_BAD_ALU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn > 4'd3) |=> ($stable(of_q) && $stable(zf_q) && $stable(sf_q))); // R9

  AST_BAD_ALU_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn > 4'd3) |-> (result == '0)); // R9

  AST_BAD_JMP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_fn > 4'd6) |-> !take_branch); // R10

  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_fn == 4'd0) |-> take_branch); // R8

  AST_LOGIC_CLEARS_OF: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cc && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !of_q); // R5

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    zf_q |-> !sf_q); // R4

endmodule

bind alu_cc_unit alu_cc_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .alu_fn(alu_fn), .set_cc(set_cc), .jmp_fn(jmp_fn), .result(result),
  .of_q(of_q), .zf_q(zf_q), .sf_q(sf_q), .take_branch(take_branch)
);

// File: tb/alu_cc_unit_tb.sv
`timescale 1ns/1ps
module alu_cc_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  alu_fn = '0, jmp_fn = '0;
  logic        set_cc = 1'b0;
  logic [31:0] result;
  logic        of_q, zf_q, sf_q, take_branch, alu_fn_bad, jmp_fn_bad;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit m_of = 1'b0, m_zf = 1'b1, m_sf = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_fn(alu_fn), .set_cc(set_cc), .jmp_fn(jmp_fn), .result(result),
    .of_q(of_q), .zf_q(zf_q), .sf_q(sf_q), .take_branch(take_branch),
    .alu_fn_bad(alu_fn_bad), .jmp_fn_bad(jmp_fn_bad)
  );

  function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b, logic [3:0] f);
    case (f)
      4'd0: return a + b;
      4'd1: return b - a;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit exp_of(logic [31:0] a, logic [31:0] b, logic [3:0] f);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t;
    if (f == 4'd0) t = sa + sb;
    else if (f == 4'd1) t = sb - sa;
    else return 1'b0;
    return (t > 64'sd2147483647) || (t < -64'sd2147483648);
  endfunction

  function automatic bit exp_br(logic [3:0] j, bit o, bit z, bit s);
    bit l = s ^ o;
    case (j)
      4'd0: return 1'b1;
      4'd1: return l | z;
      4'd2: return l;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !l;
      4'd6: return !l && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req);
    chk(req, {29'd0, of_q, zf_q, sf_q}, {29'd0, m_of, m_zf, m_sf});
  endtask

  task automatic chk_all_jumps();
    for (int j = 0; j < 9; j++) begin
      jmp_fn = 4'(j);
      #0.1;
      chk("R8_R10 branch", {31'd0, take_branch}, {31'd0, exp_br(4'(j), m_of, m_zf, m_sf)});
      chk("R10 jmp_fn_bad", {31'd0, jmp_fn_bad}, {31'd0, j > 6});
    end
  endtask

  task automatic do_op(logic [31:0] a, logic [31:0] b, logic [3:0] f, bit s, logic [3:0] j);
    logic [31:0] r;
    opnd_a = a; opnd_b = b; alu_fn = f; set_cc = s; jmp_fn = j;
    r = exp_res(a, b, f);
    #1;
    chk(f == 0 ? "R1 add" : f == 1 ? "R2 sub" : f < 4 ? "R3 logic" : "R9 bad code", result, r);
    chk("R9 alu_fn_bad", {31'd0, alu_fn_bad}, {31'd0, f > 3});
    chk("R8_R10 branch", {31'd0, take_branch}, {31'd0, exp_br(j, m_of, m_zf, m_sf)});
    @(posedge clk);
    if (s && f <= 3) begin
      m_of = exp_of(a, b, f);
      m_zf = (r == 32'd0);
      m_sf = r[31];
    end
    #1;
    chk_flags(s && f <= 3 ? "R4_R5 flags load" : "R6_R9 flags hold");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #7;
    chk_flags("R7 reset state");
    chk_all_jumps();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk_flags("R7 after release");

    do_op(32'h7fffffff, 32'h00000001, 4'd0, 1'b1, 4'd0);   // R5 add overflow positive
    chk_all_jumps();
    do_op(32'h80000000, 32'h80000000, 4'd0, 1'b1, 4'd2);   // R5 add overflow to zero
    do_op(32'h00000001, 32'h80000000, 4'd1, 1'b1, 4'd1);   // R5 sub overflow
    chk_all_jumps();
    do_op(32'h12345678, 32'h12345678, 4'd1, 1'b1, 4'd3);   // R2 equal operands
    chk_all_jumps();
    do_op(32'h00000005, 32'h00000003, 4'd1, 1'b1, 4'd6);   // R2 B-A negative
    chk_all_jumps();
    do_op(32'hffffffff, 32'h00000001, 4'd0, 1'b0, 4'd5);   // R6 no load
    do_op(32'hf0f0f0f0, 32'h0ff00ff0, 4'd2, 1'b1, 4'd4);   // R3 AND
    do_op(32'hffffffff, 32'h7fffffff, 4'd3, 1'b1, 4'd4);   // R3 XOR negative
    chk_all_jumps();
    do_op(32'h00000000, 32'h00000000, 4'd9, 1'b1, 4'd8);   // R9 bad code, flags hold
    do_op(32'h11111111, 32'h22222222, 4'd15, 1'b1, 4'd15); // R9 R10

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [3:0] f;
      a = $urandom();
      b = ($urandom_range(0, 7) == 0) ? a : $urandom();
      if ($urandom_range(0, 5) == 0) a = {$urandom_range(0, 1) == 1, 31'h7fffffff};
      f = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
      do_op(a, b, f, $urandom_range(0, 3) != 0, 4'($urandom_range(0, 8)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule